// File: doc/BRIEF.md
# Programmable crosspoint I/O cell array

This block routes signals between a row of bidirectional pin slots under control of a loaded configuration. Every slot owns a cell with a four-way data selector whose select code follows a Gray sequence. It also has a storage element that can act as an edge register, act as a level latch or be skipped, independent inversion of every control, and an output-enable path. Each selector input, select line, clock and enable is fetched from a fixed quarter of the pins. A slot can also be told to drive a fixed level, so that it stands in for a jumper or a switch.

Software writes one configuration word per cell through an address/data port. A one-cycle release strobe then lets the pads drive. Until that strobe, and again after any reset, every pad is tri-stated. The routing pool seen by all cells is each pin's input value. A cell in input-path mode replaces its pin's pool value with the output of its storage element.

Top module: `xpt_array`

## Requirements
- R1: Writing with `cfg_we` high stores `cfg_wdata` as the configuration of cell `cfg_addr` at the clock edge. With QW = log2(NPINS/4), the fields run from the MSB down as follows: src_a, src_b, src_c, src_d (QW each); lo_set, lo_idx (QW), lo_inv; hi_set, hi_idx (QW), hi_inv; mode (2); in_path; clk_glb, clk_idx (QW), clk_inv; oe_mode (2), oe_idx (QW), oe_inv; out_inv; const_en; const_val.
- R2: Until a `cfg_done` strobe has been registered, every `pad_oe` and `pad_out` bit is 0. After the strobe, release stays set until reset.
- R3: The select code {hi, lo} picks the data input as follows: 00 gives A, 01 gives B, 11 gives C and 10 gives D.
- R4: Data input A comes from pin src_a of quarter 0 (pins 0..Q-1). B comes from pin Q+src_b, C from pin 2Q+src_c and D from pin 3Q+src_d.
- R5: Each select line takes its pin from quarter 2 when its set bit is 0, or from quarter 3 when it is 1, at position idx within that quarter. The line is inverted when its inv bit is 1.
- R6: Storage mode 0 or 3 gives a combinational path. Mode 1 captures the data on the rising edge of the cell clock. Mode 2 is transparent while the cell clock is high and holds while it is low.
- R7: When clk_glb is 0, the cell clock is pin Q+clk_idx (quarter 1). When clk_glb is 1, it is `gclk[clk_idx mod NGCLK]`. In both cases it is inverted when clk_inv is 1.
- R8: With in_path set, the storage element is loaded from the pin's own `pad_in`, and its output replaces that pin's value in the routing pool. The cell's output side then stays combinational.
- R9: oe_mode 0 disables the output and oe_mode 1 enables it. oe_mode 2 or 3 enables it from pin oe_idx of quarter 0, XOR oe_inv.
- R10: out_inv set inverts the driven data.
- R11: With const_en set, const_val replaces the selector result.
- R12: `rst_n` low clears all configuration, the release flag and every storage element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | log2(NPINS) | Cell index to write |
| cfg_wdata | input | 8*QW+15 | Configuration word |
| cfg_done | input | 1 | Release strobe |
| gclk | input | NGCLK | Dedicated global clocks |
| pad_in | input | NPINS | Pin input values |
| pad_out | output | NPINS | Pin drive values |
| pad_oe | output | NPINS | Pin output enables |

## Verification
The assertions are sampled on the configuration clock. They assume that pin inputs and global clocks settle between those edges, and that `cfg_addr` stays below NPINS. The stimulus changes pins and global clocks only at falling configuration-clock edges. It writes only valid cell indices. It never routes a cell's selector back to its own storage output, so the routing stays free of combinational loops.

// File: rtl/xpt_pkg.sv
`timescale 1ns/1ps
package xpt_pkg;
    typedef enum logic [1:0] {
        ST_BYPASS     = 2'd0,
        ST_REG        = 2'd1,
        ST_LATCH      = 2'd2,
        ST_BYPASS_ALT = 2'd3
    } st_mode_e;

    typedef enum logic [1:0] {
        OE_OFF     = 2'd0,
        OE_ON      = 2'd1,
        OE_PIN     = 2'd2,
        OE_PIN_ALT = 2'd3
    } oe_mode_e;
endpackage

// File: rtl/xpt_cfg_store.sv
`timescale 1ns/1ps
module xpt_cfg_store #(
    parameter int N  = 16,
    parameter int CW = 31,
    parameter int AW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [CW-1:0]   cfg_wdata,
    input  logic            cfg_done,
    output logic [N*CW-1:0] cfg_flat,
    output logic            rel
);
    typedef struct packed {
        logic [N-1:0][CW-1:0] w;
        logic                 rel;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we && (int'(cfg_addr) < N))
            st_d.w[cfg_addr] = cfg_wdata;
        if (cfg_done)
            st_d.rel = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_flat = st_q.w;
    assign rel      = st_q.rel;

    // R1
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> st_q.w[$past(cfg_addr)] == $past(cfg_wdata));

    // R2
    rel_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> rel);
endmodule

// File: rtl/xpt_route_mux.sv
`timescale 1ns/1ps
module xpt_route_mux (
    input  logic [3:0] d,
    input  logic [1:0] sel,
    output logic       y
);
    always_comb begin
        unique case (sel)
            2'b00:   y = d[0];
            2'b01:   y = d[1];
            2'b11:   y = d[2];
            default: y = d[3];
        endcase
    end
endmodule

// File: rtl/xpt_store.sv
`timescale 1ns/1ps
module xpt_store
    import xpt_pkg::*;
(
    input  logic     rst_n,
    input  logic     cclk,
    input  st_mode_e mode,
    input  logic     d,
    output logic     q
);
    logic reg_d, reg_q;
    logic lat_q;
    logic lat_en;

    always_comb begin
        reg_d  = (mode == ST_REG) ? d : reg_q;
        lat_en = (mode == ST_LATCH) && cclk;
    end

    always_ff @(posedge cclk or negedge rst_n) begin
        if (!rst_n) reg_q <= 1'b0;
        else        reg_q <= reg_d;
    end

    always_latch begin
        if (!rst_n)      lat_q <= 1'b0;
        else if (lat_en) lat_q <= d;
    end

    assign q = (mode == ST_LATCH) ? lat_q : reg_q;
endmodule

// File: rtl/xpt_cell.sv
`timescale 1ns/1ps
module xpt_cell
    import xpt_pkg::*;
#(
    parameter int N  = 16,
    parameter int NG = 4,
    parameter int Q  = N / 4,
    parameter int QW = $clog2(Q),
    parameter int CW = 8 * QW + 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rel,
    input  logic [CW-1:0] cfg_word,
    input  logic [N-1:0]  pool,
    input  logic          pad_in_bit,
    input  logic [NG-1:0] gclk,
    output logic          out_bit,
    output logic          oe_bit,
    output logic          pool_bit
);
    typedef struct packed {
        logic [QW-1:0] src_a;
        logic [QW-1:0] src_b;
        logic [QW-1:0] src_c;
        logic [QW-1:0] src_d;
        logic          lo_set;
        logic [QW-1:0] lo_idx;
        logic          lo_inv;
        logic          hi_set;
        logic [QW-1:0] hi_idx;
        logic          hi_inv;
        st_mode_e      mode;
        logic          in_path;
        logic          clk_glb;
        logic [QW-1:0] clk_idx;
        logic          clk_inv;
        oe_mode_e      oe_mode;
        logic [QW-1:0] oe_idx;
        logic          oe_inv;
        logic          out_inv;
        logic          const_en;
        logic          const_val;
    } cell_cfg_t;

    cell_cfg_t c;
    assign c = cell_cfg_t'(cfg_word);

    logic [3:0] mux_d;
    logic [1:0] mux_sel;
    logic       mux_y;
    logic       data;
    logic       cclk;
    logic       st_in;
    logic       st_q;
    logic       stores;
    logic       out_val;
    logic       oe_raw;

    always_comb begin
        mux_d[0] = pool[int'(c.src_a)];
        mux_d[1] = pool[Q + int'(c.src_b)];
        mux_d[2] = pool[2 * Q + int'(c.src_c)];
        mux_d[3] = pool[3 * Q + int'(c.src_d)];
        mux_sel[0] = (c.lo_set ? pool[3 * Q + int'(c.lo_idx)]
                               : pool[2 * Q + int'(c.lo_idx)]) ^ c.lo_inv;
        mux_sel[1] = (c.hi_set ? pool[3 * Q + int'(c.hi_idx)]
                               : pool[2 * Q + int'(c.hi_idx)]) ^ c.hi_inv;
    end

    xpt_route_mux i_mux (
        .d   (mux_d),
        .sel (mux_sel),
        .y   (mux_y)
    );

    always_comb begin
        data   = c.const_en ? c.const_val : mux_y;
        cclk   = (c.clk_glb ? gclk[int'(c.clk_idx) % NG]
                            : pool[Q + int'(c.clk_idx)]) ^ c.clk_inv;
        st_in  = c.in_path ? pad_in_bit : data;
        stores = (c.mode == ST_REG) || (c.mode == ST_LATCH);
    end

    xpt_store i_store (
        .rst_n (rst_n),
        .cclk  (cclk),
        .mode  (c.mode),
        .d     (st_in),
        .q     (st_q)
    );

    always_comb begin
        if (c.in_path) begin
            out_val  = data;
            pool_bit = stores ? st_q : pad_in_bit;
        end else begin
            out_val  = stores ? st_q : data;
            pool_bit = pad_in_bit;
        end
        unique case (c.oe_mode)
            OE_OFF:  oe_raw = 1'b0;
            OE_ON:   oe_raw = 1'b1;
            default: oe_raw = pool[int'(c.oe_idx)] ^ c.oe_inv;
        endcase
        out_bit = rel & (out_val ^ c.out_inv);
        oe_bit  = rel & oe_raw;
    end

    // R11
    const_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && c.const_en && !c.in_path && !stores)
            |-> out_bit == (c.const_val ^ c.out_inv));

    // R9
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c.oe_mode == OE_OFF) |-> !oe_bit);
endmodule

// File: rtl/xpt_array.sv
`timescale 1ns/1ps
module xpt_array #(
    parameter int NPINS = 16,
    parameter int NGCLK = 4,
    localparam int Q    = NPINS / 4,
    localparam int QW   = $clog2(Q),
    localparam int CW   = 8 * QW + 15,
    localparam int AW   = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [CW-1:0]    cfg_wdata,
    input  logic             cfg_done,
    input  logic [NGCLK-1:0] gclk,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    logic [NPINS*CW-1:0] cfg_flat;
    logic                rel;
    logic [NPINS-1:0]    pool;

    xpt_cfg_store #(.N(NPINS), .CW(CW), .AW(AW)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_done  (cfg_done),
        .cfg_flat  (cfg_flat),
        .rel       (rel)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_cell
        xpt_cell #(.N(NPINS), .NG(NGCLK), .Q(Q), .QW(QW), .CW(CW)) i_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .rel        (rel),
            .cfg_word   (cfg_flat[i*CW +: CW]),
            .pool       (pool),
            .pad_in_bit (pad_in[i]),
            .gclk       (gclk),
            .out_bit    (pad_out[i]),
            .oe_bit     (pad_oe[i]),
            .pool_bit   (pool[i])
        );
    end

    // R2
    no_drive_before_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rel |-> (pad_oe == '0) && (pad_out == '0));
endmodule

// File: tb/test_xpt_array.sv
`timescale 1ns/1ps
module test_xpt_array;
    localparam int N  = 16;
    localparam int CW = 31;

    typedef struct packed {
        logic [1:0] src_a, src_b, src_c, src_d;
        logic lo_set; logic [1:0] lo_idx; logic lo_inv;
        logic hi_set; logic [1:0] hi_idx; logic hi_inv;
        logic [1:0] mode;
        logic in_path;
        logic clk_glb; logic [1:0] clk_idx; logic clk_inv;
        logic [1:0] oe_mode; logic [1:0] oe_idx; logic oe_inv;
        logic out_inv;
        logic const_en;
        logic const_val;
    } bcfg_t;

    // {pins, expected pad_out[10]}; pin12 = lo select, pin13 = hi select
    localparam logic [16:0] VEC [8] = '{
        {16'h0002, 1'b1}, {16'hCFFD, 1'b0},
        {16'h1040, 1'b1}, {16'hDFBF, 1'b0},
        {16'h3100, 1'b1}, {16'hFEFF, 1'b0},
        {16'hA000, 1'b1}, {16'h6FFF, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic          cfg_done = 1'b0;
    logic [3:0]    gclk = '0;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out;
    logic [N-1:0]  pad_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xpt_array i_xpt_array (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_done(cfg_done), .gclk(gclk),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input bcfg_t c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = c;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
    endtask

    task automatic pins(input logic [N-1:0] v);
        @(negedge clk);
        pad_in = v;
        #1;
    endtask

    function automatic bcfg_t base();
        bcfg_t c = '0;
        c.src_a = 2'd1; c.src_b = 2'd2; c.src_c = 2'd0; c.src_d = 2'd3;
        c.lo_set = 1'b1; c.lo_idx = 2'd0;
        c.hi_set = 1'b1; c.hi_idx = 2'd1;
        c.oe_mode = 2'd1;
        c.clk_idx = 2'd1;
        return c;
    endfunction

    initial begin
        bcfg_t c;
        #1;
        chk("R12 reset pad_oe", |pad_oe, 1'b0);
        chk("R12 reset pad_out", |pad_out, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // R2: configured but not released
        wr(10, base());
        pins(16'h0002);
        chk("R2 oe held before release", pad_oe[10], 1'b0);
        chk("R2 out held before release", pad_out[10], 1'b0);
        @(negedge clk); cfg_done = 1'b1;
        @(negedge clk); cfg_done = 1'b0; #1;
        chk("R2 oe after release", pad_oe[10], 1'b1);

        // R3 R4 R5: vector walk across all select codes
        for (int k = 0; k < 8; k++) begin
            pins(VEC[k][16:1]);
            chk($sformatf("R3 R4 vector %0d", k), pad_out[10], VEC[k][0]);
        end

        // R5 select inversion: pins 12,13 low, lo inverted gives code 01 (B = pin6)
        c = base(); c.lo_inv = 1'b1; wr(10, c);
        pins(16'h0040);
        chk("R5 lo_inv picks B", pad_out[10], 1'b1);

        // R10 output inversion
        c = base(); c.out_inv = 1'b1; wr(10, c);
        pins(16'h0002);
        chk("R10 out_inv", pad_out[10], 1'b0);

        // R11 constant
        c = base(); c.const_en = 1'b1; c.const_val = 1'b1; wr(10, c);
        pins(16'h0000);
        chk("R11 const 1", pad_out[10], 1'b1);
        c.const_val = 1'b0; wr(10, c);
        pins(16'hFFFF);
        chk("R11 const 0", pad_out[10], 1'b0);

        // R9 output enable
        c = base(); c.oe_mode = 2'd2; c.oe_idx = 2'd3; wr(10, c);
        pins(16'h0008);
        chk("R9 oe routed high", pad_oe[10], 1'b1);
        pins(16'h0000);
        chk("R9 oe routed low", pad_oe[10], 1'b0);
        c.oe_inv = 1'b1; wr(10, c);
        chk("R9 oe routed inverted", pad_oe[10], 1'b1);
        c.oe_mode = 2'd0; wr(10, c);
        pins(16'h0008);
        chk("R9 oe off", pad_oe[10], 1'b0);

        // R6 R7 register on pin5 rising
        c = base(); c.mode = 2'd1; wr(10, c);
        pins(16'h0000);
        pins(16'h0020);
        chk("R6 reg captures 0", pad_out[10], 1'b0);
        pins(16'h0022);
        chk("R6 reg holds without edge", pad_out[10], 1'b0);
        pins(16'h0002);
        pins(16'h0022);
        chk("R6 reg captures 1", pad_out[10], 1'b1);
        pins(16'h0020);
        chk("R6 reg holds 1", pad_out[10], 1'b1);

        // R7 inverted clock: capture on pin5 falling
        c.clk_inv = 1'b1; wr(10, c);
        pins(16'h0000);
        pins(16'h0022);
        chk("R7 clk_inv no capture on rise", pad_out[10], 1'b0);
        pins(16'h0002);
        chk("R7 clk_inv captures on fall", pad_out[10], 1'b1);

        // R7 global clock 2
        c = base(); c.mode = 2'd1; c.clk_glb = 1'b1; c.clk_idx = 2'd2; wr(10, c);
        pins(16'h0000);
        @(negedge clk); gclk[1] = 1'b1; @(negedge clk); gclk[1] = 1'b0; #1;
        chk("R7 other global clock ignored", pad_out[10], 1'b1);
        @(negedge clk); gclk[2] = 1'b1; @(negedge clk); gclk[2] = 1'b0; #1;
        chk("R7 global clock captures", pad_out[10], 1'b0);

        // R6 latch on pin5 level
        c = base(); c.mode = 2'd2; wr(10, c);
        pins(16'h0022);
        chk("R6 latch transparent 1", pad_out[10], 1'b1);
        pins(16'h0020);
        chk("R6 latch transparent 0", pad_out[10], 1'b0);
        pins(16'h0000);
        pins(16'h0002);
        chk("R6 latch holds", pad_out[10], 1'b0);

        // R8 input path on cell 1, observed through cell 10 route A
        c = base(); c.mode = 2'd1; c.in_path = 1'b1; c.oe_mode = 2'd0; wr(1, c);
        wr(10, base());
        pins(16'h0000);
        pins(16'h0020);
        pins(16'h0022);
        chk("R8 pool holds stored value", pad_out[10], 1'b0);
        pins(16'h0002);
        pins(16'h0022);
        chk("R8 pool sees captured pin", pad_out[10], 1'b1);
        pins(16'h0020);
        chk("R8 pool ignores raw pin", pad_out[10], 1'b1);

        // R12 reset mid-run
        @(negedge clk); rst_n = 1'b0; #1;
        chk("R12 reset clears oe", |pad_oe, 1'b0);
        chk("R12 reset clears out", |pad_out, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R12 release cleared by reset", |pad_oe, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule